// File: doc/BRIEF.md
# Light-Sensor Configuration Register Slave on I2C

This block is the serial-bus front end of an ambient light sensor controller. It watches the I2C clock and data lines with the system clock. It finds START and STOP conditions and answers only to the fixed 7-bit device address 7'b1000100. Behind the bus it keeps a small register space. That space holds an operating-mode byte, a conversion-setup byte, the live 16-bit conversion result, and a pair of 16-bit window thresholds. The surrounding sensing logic reads the thresholds and the setup fields straight from the block's outputs.

A host writes by sending the device address with the write bit, then a register pointer, then one or more data bytes. It reads by sending the address and pointer, then a repeated START, then the address with the read bit. It keeps acknowledging for as long as it wants more bytes. The pointer advances after every data byte. Any data byte that moves to or from register 00h ends with a one-cycle pulse. The sensing logic uses that pulse to clear its interrupt flag.

The data line is open drain. The block only asserts an enable that pulls the line low and never drives it high.

Top module: `lux_i2c_regslave`

## Requirements
- R1: After reset the mode field, persistence field, resolution field and range field all read 0. The low threshold is 16'h0000, the high threshold is 16'hFFFF, and the SDA pull-down is released.
- R2: An address byte whose upper 7 bits equal 7'b1000100 is acknowledged. Any other address is not acknowledged, and the block then leaves SDA released and changes no register until the next START or STOP.
- R3: A write transfer sends the address byte with bit 0 = 0, a pointer byte and data. It receives an ACK (SDA low in the ninth clock) after each byte and stores the data at the pointer.
- R4: The pointer increments after each data byte, so consecutive bytes of one transfer land in consecutive registers. Registers 04h/05h are the low threshold LSB/MSB and 06h/07h are the high threshold LSB/MSB.
- R5: A read transfer sends the address and pointer, then a repeated START, then the address byte with bit 0 = 1. The block then returns register bytes MSB first and keeps going while the host ACKs. A host NACK ends the read.
- R6: Registers 02h and 03h return the conversion input's low and high byte, and writes to them have no effect.
- R7: Pointers above 07h read as 00h, and writes to them change nothing.
- R8: Register 00h holds the mode in bits 7:5 and the persistence in bits 1:0. Bit 2 reads the live interrupt flag input and bits 4:3 read 0. Register 01h holds the resolution in bits 3:2 and the range in bits 1:0, and bits 7:4 read 0.
- R9: Each data byte written to or read from register 00h raises the clear output for exactly one clock after the byte's eighth bit. Bytes at other registers raise no pulse.
- R10: A START seen at any point, including in the middle of a byte, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull_o | output | 1 | Pull the data line low when 1 |
| conv_data_i | input | 16 | Latest conversion result |
| irq_flag_i | input | 1 | Interrupt flag from the sensing logic |
| mode_o | output | 3 | Operating mode field |
| persist_o | output | 2 | Persistence field |
| resol_o | output | 2 | Resolution field |
| range_o | output | 2 | Range field |
| thr_lo_o | output | 16 | Low window threshold |
| thr_hi_o | output | 16 | High window threshold |
| irq_clr_o | output | 1 | One-cycle clear pulse after a register 00h data byte |

## Verification
The SCL level reaches the byte engine three system clocks after a pin change. The engine then moves the SDA pull-down one clock later, and a register write lands one clock after that. The bench holds every bus level for eight system clocks on each side of an SCL edge. It samples SDA at the middle of the SCL-high phase, so each acknowledge and read bit has settled. Configuration outputs are checked only after the STOP, which is many clocks past the write. The clear pulse arrives about four clocks after the SCL fall that ends a register 00h byte. A monitor counts these pulses for the whole run, and the bench compares the count after each transfer.

// File: rtl/lux_i2c_pkg.sv
package lux_i2c_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_REGS  = 8;
  localparam int unsigned THR_BYTES = 4;
  localparam int unsigned THR_BASE  = 4;
  localparam logic [6:0]  DEV_ADDR  = 7'b1000100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACK_DEV, ST_REG, ST_ACK_REG,
    ST_WDATA, ST_ACK_W, ST_RDATA, ST_RACK, ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic [SYNC_STAGES-1:0] scl_sh_n, sda_sh_n;
  logic scl_d, sda_d, scl_lvl;

  assign scl_sh_n = {scl_sh[SYNC_STAGES-2:0], scl_i};
  assign sda_sh_n = {sda_sh[SYNC_STAGES-2:0], sda_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= scl_sh_n;
      sda_sh <= sda_sh_n;
      scl_d  <= scl_sh[SYNC_STAGES-1];
      sda_d  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import lux_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_pull,
  output logic              clr_pulse
);
  localparam int unsigned CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  bus_st_e           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-2:0] tx_q, tx_n;
  logic [BYTE_W-1:0] ptr_q, ptr_n;
  logic [BYTE_W-1:0] wa_q, wa_n, wd_q, wd_n;
  logic              we_q, we_n;
  logic              oe_q, oe_n;
  logic              clr_q, clr_n;
  logic              rw_q, rw_n;
  logic              nack_q, nack_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    tx_n   = tx_q;
    ptr_n  = ptr_q;
    wa_n   = wa_q;
    wd_n   = wd_q;
    we_n   = 1'b0;
    oe_n   = oe_q;
    clr_n  = 1'b0;
    rw_n   = rw_q;
    nack_n = nack_q;
    if (start_det) begin
      st_n  = ST_DEV;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_REG, ST_WDATA: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (st_q == ST_DEV) begin
              if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                st_n = ST_ACK_DEV;
                oe_n = 1'b1;
                rw_n = sh_q[0];
              end else begin
                st_n = ST_SKIP;
              end
            end else if (st_q == ST_REG) begin
              ptr_n = sh_q;
              st_n  = ST_ACK_REG;
              oe_n  = 1'b1;
            end else begin
              we_n  = 1'b1;
              wa_n  = ptr_q;
              wd_n  = sh_q;
              clr_n = (ptr_q == '0);
              ptr_n = ptr_q + 1'b1;
              st_n  = ST_ACK_W;
              oe_n  = 1'b1;
            end
          end
        end
        ST_ACK_DEV: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw_q) begin
              tx_n = rd_byte[BYTE_W-2:0];
              oe_n = ~rd_byte[BYTE_W-1];
              st_n = ST_RDATA;
            end else begin
              oe_n = 1'b0;
              st_n = ST_REG;
            end
          end
        end
        ST_ACK_REG, ST_ACK_W: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            st_n  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_n  = 1'b0;
              st_n  = ST_RACK;
              clr_n = (ptr_q == '0);
              ptr_n = ptr_q + 1'b1;
            end else begin
              oe_n  = ~tx_q[BYTE_W-2];
              tx_n  = {tx_q[BYTE_W-3:0], 1'b0};
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_n = sda_lvl;
          end else if (scl_fall) begin
            if (!nack_q) begin
              tx_n  = rd_byte[BYTE_W-2:0];
              oe_n  = ~rd_byte[BYTE_W-1];
              cnt_n = '0;
              st_n  = ST_RDATA;
            end else begin
              st_n = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      wa_q   <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
      oe_q   <= 1'b0;
      clr_q  <= 1'b0;
      rw_q   <= 1'b0;
      nack_q <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      tx_q   <= tx_n;
      ptr_q  <= ptr_n;
      wa_q   <= wa_n;
      wd_q   <= wd_n;
      we_q   <= we_n;
      oe_q   <= oe_n;
      clr_q  <= clr_n;
      rw_q   <= rw_n;
      nack_q <= nack_n;
    end
  end

  assign ptr       = ptr_q;
  assign wr_en     = we_q;
  assign wr_addr   = wa_q;
  assign wr_data   = wd_q;
  assign sda_pull  = oe_q;
  assign clr_pulse = clr_q;

  // R9
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
  // R2
  skip_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |-> !oe_q);
  // R10
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_DEV) && !oe_q && (cnt_q == '0));
endmodule

// File: rtl/sensor_regfile.sv
module sensor_regfile
  import lux_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_addr,
  input  logic [15:0]       conv_data,
  input  logic              irq_flag,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [2:0]        mode_o,
  output logic [1:0]        persist_o,
  output logic [1:0]        resol_o,
  output logic [1:0]        range_o,
  output logic [15:0]       thr_lo_o,
  output logic [15:0]       thr_hi_o
);
  logic [2:0] mode_q, mode_n;
  logic [1:0] pers_q, pers_n;
  logic [3:0] setup_q, setup_n;
  logic [BYTE_W-1:0] thr_q [THR_BYTES];

  always_comb begin
    mode_n  = mode_q;
    pers_n  = pers_q;
    setup_n = setup_q;
    if (wr_en && wr_addr == 8'h00) begin
      mode_n = wr_data[7:5];
      pers_n = wr_data[1:0];
    end
    if (wr_en && wr_addr == 8'h01) begin
      setup_n = wr_data[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      pers_q  <= '0;
      setup_q <= '0;
    end else begin
      mode_q  <= mode_n;
      pers_q  <= pers_n;
      setup_q <= setup_n;
    end
  end

  for (genvar g = 0; g < THR_BYTES; g++) begin : g_thr
    localparam logic [BYTE_W-1:0] ADR = BYTE_W'(THR_BASE + g);
    localparam logic [BYTE_W-1:0] RST = (g >= THR_BYTES / 2) ? '1 : '0;
    logic [BYTE_W-1:0] nxt;
    always_comb nxt = (wr_en && wr_addr == ADR) ? wr_data : thr_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q[g] <= RST;
      else        thr_q[g] <= nxt;
    end
  end

  always_comb begin
    unique case (rd_addr)
      8'h00:   rd_byte = {mode_q, 2'b00, irq_flag, pers_q};
      8'h01:   rd_byte = {4'h0, setup_q};
      8'h02:   rd_byte = conv_data[7:0];
      8'h03:   rd_byte = conv_data[15:8];
      8'h04:   rd_byte = thr_q[0];
      8'h05:   rd_byte = thr_q[1];
      8'h06:   rd_byte = thr_q[2];
      8'h07:   rd_byte = thr_q[3];
      default: rd_byte = '0;
    endcase
  end

  assign mode_o    = mode_q;
  assign persist_o = pers_q;
  assign resol_o   = setup_q[3:2];
  assign range_o   = setup_q[1:0];
  assign thr_lo_o  = {thr_q[1], thr_q[0]};
  assign thr_hi_o  = {thr_q[3], thr_q[2]};

  // R7
  high_ptr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= NUM_REGS) |=> $stable(thr_lo_o) && $stable(thr_hi_o)
      && $stable(mode_o) && $stable(persist_o) && $stable(resol_o) && $stable(range_o));
  // R6
  data_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 8'h02 || wr_addr == 8'h03)) |=> $stable(thr_lo_o)
      && $stable(thr_hi_o) && $stable(mode_o) && $stable(resol_o));
  // R3
  thr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h04) |=> thr_lo_o[7:0] == $past(wr_data));
  // R8
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h00) |=> mode_o == $past(wr_data[7:5]));
endmodule

// File: rtl/lux_i2c_regslave.sv
module lux_i2c_regslave
  import lux_i2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  input  logic [15:0] conv_data_i,
  input  logic        irq_flag_i,
  output logic [2:0]  mode_o,
  output logic [1:0]  persist_o,
  output logic [1:0]  resol_o,
  output logic [1:0]  range_o,
  output logic [15:0] thr_lo_o,
  output logic [15:0] thr_hi_o,
  output logic        irq_clr_o
);
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rd_byte, ptr, wr_addr, wr_data;
  logic wr_en;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine u_eng (
    .clk(clk), .rst_n(rst_core_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_pull(sda_pull_o), .clr_pulse(irq_clr_o)
  );

  sensor_regfile u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .conv_data(conv_data_i),
    .irq_flag(irq_flag_i), .rd_byte(rd_byte), .mode_o(mode_o),
    .persist_o(persist_o), .resol_o(resol_o), .range_o(range_o),
    .thr_lo_o(thr_lo_o), .thr_hi_o(thr_hi_o)
  );
endmodule

// File: tb/sim_lux_i2c_regslave.sv
module sim_lux_i2c_regslave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_line;
  logic sda_pull;
  logic [15:0] conv_data = 16'h0000;
  logic irq_flag = 1'b0;
  logic [2:0] mode;
  logic [1:0] persist, resol, range_f;
  logic [15:0] thr_lo, thr_hi;
  logic irq_clr;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  logic [7:0] exp_v [$];
  string      exp_t [$];
  logic [7:0] obs;
  event       obs_ev;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = ~(sda_pull | m_low);

  lux_i2c_regslave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .conv_data_i(conv_data), .irq_flag_i(irq_flag),
    .mode_o(mode), .persist_o(persist), .resol_o(resol), .range_o(range_f),
    .thr_lo_o(thr_lo), .thr_hi_o(thr_hi), .irq_clr_o(irq_clr)
  );

  always @(posedge clk) if (rst_n && irq_clr) pulses++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic qw();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_low = ~b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bit_in(output logic b);
    m_low = 1'b0; qw(); m_scl = 1'b1; qw(); b = sda_line; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic byte_out(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic byte_in(output logic [7:0] d, input logic mack);
    logic b;
    d = '0;
    for (int i = 0; i < 8; i++) begin bit_in(b); d = {d[6:0], b}; end
    bit_out(~mack);
  endtask

  task automatic m_start();
    m_low = 1'b1; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic m_rstart();
    m_low = 1'b0; qw(); m_scl = 1'b1; qw(); m_low = 1'b1; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic m_stop();
    m_low = 1'b1; qw(); m_scl = 1'b1; qw(); m_low = 1'b0; qw();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d [4], input int n, input string tag);
    logic ack;
    m_start();
    byte_out(8'h88, ack); chk({tag, " addr ack"}, ack, 1'b1);
    byte_out(a, ack);     chk({tag, " ptr ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      byte_out(d[i], ack); chk({tag, " data ack"}, ack, 1'b1);
    end
    m_stop();
  endtask

  task automatic rd(input logic [7:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    m_start();
    byte_out(8'h88, ack); chk({tag, " addr ack"}, ack, 1'b1);
    byte_out(a, ack);     chk({tag, " ptr ack"}, ack, 1'b1);
    m_rstart();
    byte_out(8'h89, ack); chk({tag, " raddr ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      byte_in(d, i < n - 1);
      obs = d;
      ->obs_ev;
    end
    m_stop();
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] v);
    exp_v.push_back(v);
    exp_t.push_back(tag);
  endtask

  initial begin
    forever begin
      @(obs_ev);
      if (exp_v.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 unexpected byte: got %0h expected none", obs);
      end else begin
        chk(exp_t.pop_front(), obs, exp_v.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    chk("R1 mode", mode, 3'd0);
    chk("R1 persist", persist, 2'd0);
    chk("R1 resol", resol, 2'd0);
    chk("R1 range", range_f, 2'd0);
    chk("R1 thr_lo", thr_lo, 16'h0000);
    chk("R1 thr_hi", thr_hi, 16'hFFFF);
    chk("R1 sda released", sda_pull, 1'b0);

    // R1 R5 reset values of high threshold bytes through the bus
    expect_byte("R1 reg06", 8'hFF);
    expect_byte("R1 reg07", 8'hFF);
    rd(8'h06, 2, "R5");

    // R3 R8 R9 register 00h
    wr(8'h00, '{8'hBE, 8'h00, 8'h00, 8'h00}, 1, "R3");
    chk("R8 mode", mode, 3'd5);
    chk("R8 persist", persist, 2'd2);
    chk("R9 pulse after reg00 write", pulses, 1);
    expect_byte("R8 reg00 flag0", 8'hA2);
    rd(8'h00, 1, "R8");
    chk("R9 pulse after reg00 read", pulses, 2);
    irq_flag = 1'b1;
    expect_byte("R8 reg00 flag1", 8'hA6);
    rd(8'h00, 1, "R8");
    chk("R9 pulse after second read", pulses, 3);

    // R8 register 01h
    wr(8'h01, '{8'hFB, 8'h00, 8'h00, 8'h00}, 1, "R8");
    chk("R8 resol", resol, 2'd2);
    chk("R8 range", range_f, 2'd3);
    expect_byte("R8 reg01", 8'h0B);
    rd(8'h01, 1, "R8");
    chk("R9 no pulse for reg01", pulses, 3);

    // R4 auto-increment write, R5 burst read
    wr(8'h04, '{8'h11, 8'h22, 8'h33, 8'h44}, 4, "R4");
    chk("R4 thr_lo", thr_lo, 16'h2211);
    chk("R4 thr_hi", thr_hi, 16'h4433);
    expect_byte("R5 reg04", 8'h11);
    expect_byte("R5 reg05", 8'h22);
    expect_byte("R5 reg06", 8'h33);
    expect_byte("R5 reg07", 8'h44);
    rd(8'h04, 4, "R5");

    // R6 read-only conversion data
    conv_data = 16'hBEEF;
    expect_byte("R6 reg02", 8'hEF);
    expect_byte("R6 reg03", 8'hBE);
    rd(8'h02, 2, "R6");
    wr(8'h02, '{8'h55, 8'h66, 8'h00, 8'h00}, 2, "R6");
    expect_byte("R6 reg02 after write", 8'hEF);
    expect_byte("R6 reg03 after write", 8'hBE);
    rd(8'h02, 2, "R6");
    chk("R6 thr_lo untouched", thr_lo, 16'h2211);

    // R7 pointers above 07h
    wr(8'h07, '{8'h99, 8'hAA, 8'h00, 8'h00}, 2, "R7");
    wr(8'h09, '{8'h77, 8'h00, 8'h00, 8'h00}, 1, "R7");
    chk("R7 thr_hi", thr_hi, 16'h9933);
    chk("R7 thr_lo", thr_lo, 16'h2211);
    expect_byte("R7 reg07", 8'h99);
    expect_byte("R7 reg08", 8'h00);
    expect_byte("R7 reg09", 8'h00);
    rd(8'h07, 3, "R7");

    // R2 wrong address
    m_start();
    byte_out(8'h8A, ack); chk("R2 mismatch nack", ack, 1'b0);
    byte_out(8'h04, ack); chk("R2 ignored ptr nack", ack, 1'b0);
    byte_out(8'h00, ack); chk("R2 ignored data nack", ack, 1'b0);
    m_stop();
    chk("R2 thr_lo unchanged", thr_lo, 16'h2211);

    // R10 START in the middle of a byte
    m_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
    m_rstart();
    byte_out(8'h88, ack); chk("R10 addr ack", ack, 1'b1);
    byte_out(8'h05, ack); chk("R10 ptr ack", ack, 1'b1);
    byte_out(8'hC3, ack); chk("R10 data ack", ack, 1'b1);
    m_stop();
    chk("R10 thr_lo", thr_lo, 16'hC311);
    chk("R9 final pulse count", pulses, 3);

    repeat (20) @(negedge clk);
    chk("R5 all expected bytes seen", exp_v.size(), 0);
    finish_run();
  end
endmodule